// File: doc/BRIEF.md
# Distance-Based TLB Prefetcher

This block sits beside a TLB and watches every virtual page number (VPN) the TLB is asked to translate. It takes the difference between each VPN and the previous one, remembers which difference came after which, and uses that history to guess the next page. When the guess is new, it sends a fetch request for that page's translation. The translation that comes back goes into a small private buffer, not into the TLB, so a wrong guess never displaces a useful TLB entry.

The buffer is probed in parallel with the TLB. On a probe hit the block returns the physical page number in the same cycle so it can be handed to the TLB refill path, and the entry leaves the buffer. Page-table access is outside the block: a request/response pair carries the predicted VPN out and the physical page number back. For a stream such as 1, 2, 4, 5, 7, 8, two table entries (a step of 1 is followed by 2, a step of 2 by 1) cover the whole pattern.

Top module: `dist_tlb_prefetcher`

## Requirements
- R1: After reset no request is pending (`pfReqValid` low) and every lookup misses.
- R2: The distance of an access is its VPN minus the previous access's VPN, modulo 2^VPN_W. The first access after reset has no distance: it neither trains nor issues a request.
- R3: Training runs on every access, whatever the TLB outcome. When an access has a non-zero distance and an earlier non-zero distance is held, the table slot selected by the low log2(TAB_N) bits of the earlier distance gets that earlier distance as its tag and the new distance as its stored successor.
- R4: The prediction reads the slot selected by the low bits of the new distance, after the same access's training write. If that slot is valid and its tag equals the new distance, the target is VPN plus the stored successor, and the request appears with `pfReqValid` high one cycle after the access.
- R5: An access with zero distance neither trains, nor changes the held distance, nor issues a request.
- R6: One request is outstanding at a time. `pfReqValid` and `pfReqVpn` stay steady until `pfReqReady` is seen high; predictions made while a request is outstanding are dropped, not queued.
- R7: No request is issued when the target VPN is already in the prefetch buffer.
- R8: A response (`pfRespValid` while a request has been accepted and not yet answered) stores the requested VPN with `pfRespPpn` into the 4-entry buffer, overwriting slots in insertion order so the oldest insertion is displaced first.
- R9: A lookup of a buffered VPN raises `lookupHit` and drives `refillPpn` in the same cycle; that entry is removed at the next clock edge, so a repeat lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A TLB access happens this cycle |
| accVpn | input | VPN_W | VPN of that access |
| lookupValid | input | 1 | Probe the prefetch buffer this cycle |
| lookupVpn | input | VPN_W | VPN being probed |
| lookupHit | output | 1 | Probe found the VPN; refill data valid |
| refillPpn | output | PPN_W | Physical page number for the TLB refill |
| pfReqValid | output | 1 | Prefetch request pending |
| pfReqVpn | output | VPN_W | VPN whose translation is requested |
| pfReqReady | input | 1 | Request accepted by the walker |
| pfRespValid | input | 1 | Translation for the accepted request returns |
| pfRespPpn | input | PPN_W | Returned physical page number |

## Verification
The assertions take it that the walker answers only a request it has accepted, and that a lookup and an access are never used to race the same buffer entry against a fresh insertion in one cycle. The stimulus keeps to this: each response is driven only after the handshake, lookups and accesses occupy separate cycles, and the random part mixes step sizes, repeated pages, table-slot aliases (1 against 17) and withheld ready so that duplicate, dropped and evicted predictions all occur.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  typedef enum logic [1:0] {
    PF_IDLE,
    PF_REQ,
    PF_WAIT
  } pfState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic histWr;   // record current VPN
    logic distWr;   // record new distance
    logic tabWr;    // train the distance table
    logic reqLoad;  // capture predicted target as pending request
    logic bufIns;   // store response in prefetch buffer
  } dpfStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic vpnSeen;
    logic distSeen;
    logic distZero;
    logic predOk;
    logic targetInBuf;
  } dpfFlags_t;

endpackage

// File: rtl/dpf_ctrl.sv
module dpf_ctrl
  import dpf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        pfReqReady,
  input  logic        pfRespValid,
  input  dpfFlags_t   flags,
  output dpfStrobes_t strobes,
  output logic        reqValid
);

  pfState_e state, stateNext;

  always_comb begin
    strobes        = '0;
    strobes.histWr = accValid;
    strobes.distWr = accValid && flags.vpnSeen && !flags.distZero;
    strobes.tabWr  = strobes.distWr && flags.distSeen;
    strobes.reqLoad = strobes.distWr && flags.predOk && !flags.targetInBuf
                      && (state == PF_IDLE);
    strobes.bufIns = (state == PF_WAIT) && pfRespValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      PF_IDLE: if (strobes.reqLoad) stateNext = PF_REQ;
      PF_REQ:  if (pfReqReady)      stateNext = PF_WAIT;
      PF_WAIT: if (pfRespValid)     stateNext = PF_IDLE;
      default: stateNext = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PF_IDLE;
    else       state <= stateNext;
  end

  assign reqValid = (state == PF_REQ);

endmodule

// File: rtl/dpf_datapath.sv
module dpf_datapath
  import dpf_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 16,
  parameter int TAB_N = 16,
  parameter int BUF_N = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [VPN_W-1:0] accVpn,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [PPN_W-1:0] pfRespPpn,
  input  dpfStrobes_t      strobes,
  output dpfFlags_t        flags,
  output logic             lookupHit,
  output logic [PPN_W-1:0] refillPpn,
  output logic [VPN_W-1:0] pendVpn
);

  localparam int TAB_IW = $clog2(TAB_N);
  localparam int BUF_IW = $clog2(BUF_N);

  logic [VPN_W-1:0] lastVpn, lastDist;
  logic             vpnSeen, distSeen;

  logic [TAB_N-1:0] tabVal;
  logic [VPN_W-1:0] tabTag  [TAB_N];
  logic [VPN_W-1:0] tabNext [TAB_N];

  logic [BUF_N-1:0] bufVal;
  logic [VPN_W-1:0] bufVpn [BUF_N];
  logic [PPN_W-1:0] bufPpn [BUF_N];
  logic [BUF_IW-1:0] wrPtr;

  logic [VPN_W-1:0]  distNew, predDist, target;
  logic [TAB_IW-1:0] rdIdx, wrIdx;
  logic              trainNow, wrAliases, predOk;
  logic [BUF_N-1:0]  tgtMatch, lookMatch;

  assign distNew  = accVpn - lastVpn;
  assign rdIdx    = distNew[TAB_IW-1:0];
  assign wrIdx    = lastDist[TAB_IW-1:0];
  // the training write of this access is visible to its own prediction
  assign trainNow = accValid && vpnSeen && distSeen && (distNew != '0);
  assign wrAliases = trainNow && (wrIdx == rdIdx);

  always_comb begin
    if (wrAliases) begin
      predOk   = (lastDist == distNew);
      predDist = distNew;
    end else begin
      predOk   = tabVal[rdIdx] && (tabTag[rdIdx] == distNew);
      predDist = tabNext[rdIdx];
    end
  end

  assign target = accVpn + predDist;

  for (genvar i = 0; i < BUF_N; i++) begin : g_match
    assign tgtMatch[i]  = bufVal[i] && (bufVpn[i] == target);
    assign lookMatch[i] = lookupValid && bufVal[i] && (bufVpn[i] == lookupVpn);
  end

  always_comb begin
    refillPpn = '0;
    for (int i = 0; i < BUF_N; i++)
      if (lookMatch[i]) refillPpn = refillPpn | bufPpn[i];
  end

  assign lookupHit = |lookMatch;

  assign flags.vpnSeen     = vpnSeen;
  assign flags.distSeen    = distSeen;
  assign flags.distZero    = (distNew == '0);
  assign flags.predOk      = predOk;
  assign flags.targetInBuf = |tgtMatch;

  // access history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastVpn  <= '0;
      lastDist <= '0;
      vpnSeen  <= 1'b0;
      distSeen <= 1'b0;
    end else begin
      if (strobes.histWr) begin
        lastVpn <= accVpn;
        vpnSeen <= 1'b1;
      end
      if (strobes.distWr) begin
        lastDist <= distNew;
        distSeen <= 1'b1;
      end
    end
  end

  // distance table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tabVal <= '0;
    end else if (strobes.tabWr) begin
      tabVal[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.tabWr) begin
      tabTag[wrIdx]  <= lastDist;
      tabNext[wrIdx] <= distNew;
    end
  end

  // pending request target
  always_ff @(posedge clk) begin
    if (!rstN)                pendVpn <= '0;
    else if (strobes.reqLoad) pendVpn <= target;
  end

  // prefetch buffer, insertion-order replacement
  always_ff @(posedge clk) begin
    if (!rstN)               wrPtr <= '0;
    else if (strobes.bufIns) wrPtr <= wrPtr + 1'b1;
  end

  for (genvar i = 0; i < BUF_N; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufVal[i] <= 1'b0;
      end else if (strobes.bufIns && (wrPtr == BUF_IW'(i))) begin
        bufVal[i] <= 1'b1;
      end else if (lookMatch[i]) begin
        bufVal[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobes.bufIns && (wrPtr == BUF_IW'(i))) begin
        bufVpn[i] <= pendVpn;
        bufPpn[i] <= pfRespPpn;
      end
    end
  end

  logic unusedAcc;
  assign unusedAcc = accValid & 1'b0;

endmodule

// File: rtl/dist_tlb_prefetcher.sv
module dist_tlb_prefetcher
  import dpf_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 16,
  parameter int TAB_N = 16,
  parameter int BUF_N = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [VPN_W-1:0] accVpn,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             lookupHit,
  output logic [PPN_W-1:0] refillPpn,
  output logic             pfReqValid,
  output logic [VPN_W-1:0] pfReqVpn,
  input  logic             pfReqReady,
  input  logic             pfRespValid,
  input  logic [PPN_W-1:0] pfRespPpn
);

  dpfStrobes_t strobes;
  dpfFlags_t   flags;

  dpf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .pfReqReady (pfReqReady),
    .pfRespValid(pfRespValid),
    .flags      (flags),
    .strobes    (strobes),
    .reqValid   (pfReqValid)
  );

  dpf_datapath #(
    .VPN_W(VPN_W),
    .PPN_W(PPN_W),
    .TAB_N(TAB_N),
    .BUF_N(BUF_N)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .accVpn     (accVpn),
    .lookupValid(lookupValid),
    .lookupVpn  (lookupVpn),
    .pfRespPpn  (pfRespPpn),
    .strobes    (strobes),
    .flags      (flags),
    .lookupHit  (lookupHit),
    .refillPpn  (refillPpn),
    .pendVpn    (pfReqVpn)
  );

endmodule

// File: rtl/dist_tlb_prefetcher_chk.sv
module dist_tlb_prefetcher_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             accValid,
  input logic [VPN_W-1:0] accVpn,
  input logic             lookupValid,
  input logic [VPN_W-1:0] lookupVpn,
  input logic             lookupHit,
  input logic             pfReqValid,
  input logic [VPN_W-1:0] pfReqVpn,
  input logic             pfReqReady,
  input logic             pfRespValid
);

  logic [VPN_W-1:0] ckLast;
  logic             ckSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckLast <= '0;
      ckSeen <= 1'b0;
    end else if (accValid) begin
      ckLast <= accVpn;
      ckSeen <= 1'b1;
    end
  end

  // R6: pending request holds until accepted
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    pfReqValid && !pfReqReady |=> pfReqValid && $stable(pfReqVpn));

  // R6: accepted request leaves the port
  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    pfReqValid && pfReqReady |=> !pfReqValid);

  // R9: a hit entry is gone in the next cycle
  a_r9_hit_removes: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid && lookupHit && !pfRespValid |=>
      !(lookupValid && lookupHit && (lookupVpn == $past(lookupVpn))));

  // R5: a repeat of the same page issues nothing
  a_r5_zero_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ckSeen && accValid && (accVpn == ckLast) && !pfReqValid |=> !pfReqValid);

  // R2: the first access after reset cannot predict
  a_r2_first_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ckSeen && accValid |=> !pfReqValid);

  // R4: a request appears only right after an access
  a_r4_req_after_access: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfReqValid) |-> $past(accValid));

endmodule

bind dist_tlb_prefetcher dist_tlb_prefetcher_chk #(.VPN_W(VPN_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .accValid   (accValid),
  .accVpn     (accVpn),
  .lookupValid(lookupValid),
  .lookupVpn  (lookupVpn),
  .lookupHit  (lookupHit),
  .pfReqValid (pfReqValid),
  .pfReqVpn   (pfReqVpn),
  .pfReqReady (pfReqReady),
  .pfRespValid(pfRespValid)
);

// File: tb/dist_tlb_prefetcher_test.sv
module dist_tlb_prefetcher_test;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 20;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          accValid = 1'b0;
  logic [VW-1:0] accVpn = '0;
  logic          lookupValid = 1'b0;
  logic [VW-1:0] lookupVpn = '0;
  logic          lookupHit;
  logic [PW-1:0] refillPpn;
  logic          pfReqValid;
  logic [VW-1:0] pfReqVpn;
  logic          pfReqReady = 1'b0;
  logic          pfRespValid = 1'b0;
  logic [PW-1:0] pfRespPpn = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  dist_tlb_prefetcher uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accVpn(accVpn),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .lookupHit(lookupHit),
    .refillPpn(refillPpn), .pfReqValid(pfReqValid), .pfReqVpn(pfReqVpn),
    .pfReqReady(pfReqReady), .pfRespValid(pfRespValid), .pfRespPpn(pfRespPpn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state built from the requirements
  logic [VW-1:0] mLast, mDist, mPend;
  bit            mSeen, mDSeen, mBusy;
  bit            mTV[16];
  logic [VW-1:0] mTT[16], mTN[16];
  bit            mBV[4];
  logic [VW-1:0] mBVpn[4];
  logic [PW-1:0] mBPpn[4];
  int            mWp;

  function automatic logic [PW-1:0] ppnOf(input logic [VW-1:0] v);
    return PW'(v * 7 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mSeen = 0; mDSeen = 0; mBusy = 0; mWp = 0; mLast = '0; mDist = '0; mPend = '0;
    for (int i = 0; i < 16; i++) mTV[i] = 0;
    for (int i = 0; i < 4; i++) mBV[i] = 0;
  endtask

  function automatic bit inBuf(input logic [VW-1:0] v);
    for (int i = 0; i < 4; i++) if (mBV[i] && mBVpn[i] == v) return 1;
    return 0;
  endfunction

  task automatic modelAccess(input logic [VW-1:0] v, output bit issue,
                             output logic [VW-1:0] tgt);
    logic [VW-1:0] d;
    issue = 0; tgt = '0;
    if (mSeen) begin
      d = v - mLast;
      if (d != '0) begin
        if (mDSeen) begin
          mTV[mDist[3:0]] = 1; mTT[mDist[3:0]] = mDist; mTN[mDist[3:0]] = d;
        end
        mDist = d; mDSeen = 1;
        if (mTV[d[3:0]] && mTT[d[3:0]] == d) begin
          tgt = v + mTN[d[3:0]];
          if (!inBuf(tgt) && !mBusy) issue = 1;
        end
      end
    end
    mLast = v; mSeen = 1;
  endtask

  task automatic serveReq();
    pfReqReady = 1'b1;
    @(negedge clk);
    pfReqReady = 1'b0;
    check(pfReqValid == 1'b0, "R6", "valid after accept", pfReqValid, 0);
    pfRespValid = 1'b1;
    pfRespPpn = ppnOf(mPend);
    @(negedge clk);
    pfRespValid = 1'b0;
    mBV[mWp] = 1; mBVpn[mWp] = mPend; mBPpn[mWp] = ppnOf(mPend);
    mWp = (mWp + 1) % 4;
    mBusy = 0;
  endtask

  task automatic access(input logic [VW-1:0] v, input bit serve, input string req);
    bit issue;
    logic [VW-1:0] tgt;
    @(negedge clk);
    accValid = 1'b1; accVpn = v;
    modelAccess(v, issue, tgt);
    @(negedge clk);
    accValid = 1'b0;
    if (issue) begin mBusy = 1; mPend = tgt; end
    check(pfReqValid == mBusy, req, "pfReqValid", pfReqValid, mBusy);
    if (mBusy) check(pfReqVpn == mPend, req, "pfReqVpn", pfReqVpn, mPend);
    if (serve && mBusy) serveReq();
  endtask

  task automatic lookup(input logic [VW-1:0] v, input string req);
    bit eh;
    int slot;
    eh = 0; slot = 0;
    for (int i = 0; i < 4; i++) if (mBV[i] && mBVpn[i] == v) begin eh = 1; slot = i; end
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = v;
    #1;
    check(lookupHit == eh, req, "lookupHit", lookupHit, eh);
    if (eh) check(refillPpn == mBPpn[slot], req, "refillPpn", refillPpn, mBPpn[slot]);
    @(negedge clk);
    lookupValid = 1'b0;
    if (eh) mBV[slot] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int r;
    logic [VW-1:0] cur;
    logic [VW-1:0] steps [6];
    steps[0] = 1; steps[1] = 2; steps[2] = -1; steps[3] = 17; steps[4] = 0; steps[5] = 3;
    seed = 32'h5eed;
    r = $urandom(seed);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(pfReqValid == 1'b0, "R1", "pfReqValid after reset", pfReqValid, 0);
    lookup(0, "R1");
    lookup(7, "R1");

    // R2 first access, then the 1,2,4,5,7,8 pattern (R3)
    access(1, 1, "R2");
    access(2, 1, "R2");
    access(4, 1, "R3");
    access(5, 1, "R3");
    access(7, 1, "R3");
    access(8, 1, "R3");
    // R9: hit moves entry out
    lookup(7, "R9");
    lookup(7, "R9");
    lookup(8, "R9");
    // R5: zero distance leaves history and issues nothing
    access(10, 1, "R4");
    access(10, 1, "R5");
    access(10, 1, "R5");
    access(11, 1, "R5");
    // R6: outstanding request blocks and holds
    access(13, 0, "R6");
    access(14, 0, "R6");
    repeat (3) begin
      @(negedge clk);
      check(pfReqValid == 1'b1 && pfReqVpn == mPend, "R6", "held request", pfReqVpn, mPend);
    end
    serveReq();
    // R7: duplicate target suppressed
    access(12, 1, "R7");
    access(13, 1, "R7");
    // R4 bypass of same-access write, R8 insertion-order eviction
    for (int v = 100; v <= 106; v++) access(VW'(v), 1, "R4");
    lookup(103, "R8");
    lookup(104, "R8");
    lookup(107, "R8");

    // random phase
    cur = 200;
    for (int n = 0; n < 600; n++) begin
      r = $urandom_range(99, 0);
      if (r < 75) begin
        cur = cur + steps[$urandom_range(5, 0)];
        access(cur, $urandom_range(3, 0) != 0, "R4");
      end else if (r < 90) begin
        lookup(cur + VW'($urandom_range(6, 0)) - 3, "R9");
      end else begin
        cur = VW'($urandom_range(400, 150));
        access(cur, 1, "R3");
      end
    end
    if (mBusy) serveReq();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule